// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page table entries from memory. A requester offers a virtual address with two qualifiers, one saying whether the access is a store and one saying whether it comes from user mode. The walker takes the first-level table address from a base register input. It then reads the first-level entry, which names a second-level table, and then the second-level entry, which names the physical frame. The low 12 bits of the address pass through as the page offset.

At each level the walker checks that the entry is present. It also checks that the entry allows the access, both for writing and for user mode. It ends with a one-cycle result that carries a 2-bit status and, on success, the physical address. Only one translation is in flight at a time. The memory side issues one read at a time and waits for that read's data before it does anything else.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and in the cycle after it, `busy`, `resp_valid` and `mem_req` are 0. A reset in the middle of a walk abandons that walk.
- R2: The first memory read goes to the base register value, taken when the request is accepted, plus `vaddr[31:22]` times 4. Later changes to the base register do not affect a walk that has started.
- R3: The second memory read goes to the first-level entry's bits [31:12] followed by 12 zero bits, plus `vaddr[21:12]` times 4.
- R4: A walk that passes both levels reports status 00. The physical address is the second-level entry's bits [31:12] above `vaddr[11:0]`.
- R5: A first-level entry with bit 0 (valid) equal to 0 ends the walk with status 01, after exactly one memory read.
- R6: A second-level entry with bit 0 equal to 0 ends the walk with status 10.
- R7: A store (`req_write`=1) that meets a present entry with bit 1 (writable) equal to 0, at either level, ends the walk with status 11. At any one level, not-present is checked before permission.
- R8: A user access (`req_user`=1) that meets a present entry with bit 2 (user) equal to 0, at either level, ends the walk with status 11. A kernel access does not look at bit 2.
- R9: `busy` rises in the cycle after a request is accepted while idle. It stays high up to and including the response cycle and drops in the cycle after it. A request offered while busy is ignored.
- R10: `resp_valid` is a single-cycle pulse. On any fault status `resp_paddr` is 0.
- R11: `mem_req` is a single-cycle pulse. No new read is issued until `mem_rvalid` has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 32 | First-level table base address for the current process |
| req_valid | input | 1 | Translation request strobe, taken when not busy |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access |
| req_user | input | 1 | 1 for a user-mode access |
| busy | output | 1 | Walker is working on a request |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_status | output | 2 | 00 ok, 01 absent at level 1, 10 absent at level 2, 11 protection |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| mem_req | output | 1 | One-cycle read request for a table entry |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Entry returned by memory |

## Verification
The assertions assume that memory raises `mem_rvalid` only while a read is outstanding, and no earlier than the cycle after `mem_req`. They also assume that memory never returns data for a read that was dropped by reset. The bench meets these conditions by answering each observed `mem_req` once, after a latency of one to four cycles. It never answers outside a walk and holds `mem_rvalid` low across the mid-walk reset. Request strobes offered while the walker is busy are allowed by the properties, and the bench drives one on purpose to show it is ignored.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ptbr,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_write,
  input  logic          req_user,
  output logic          busy,
  output logic          resp_valid,
  output logic [1:0]    resp_status,
  output logic [AW-1:0] resp_paddr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata
);
  localparam int OFS_W  = 12;
  localparam int IDX_W  = 10;
  localparam int FRM_W  = AW - OFS_W;
  localparam int L1_LO  = OFS_W + IDX_W;
  localparam int B_VAL  = 0;
  localparam int B_WR   = 1;
  localparam int B_USR  = 2;

  typedef enum logic [2:0] {IDLE, FETCH_L1, WAIT_L1, FETCH_L2, WAIT_L2, DONE} state_t;

  state_t            st;
  logic [AW-1:0]     va_q, base_q, tbl_q;
  logic [FRM_W-1:0]  frame_q;
  logic [1:0]        stat_q;
  logic              wr_q, usr_q;

  wire pte_present = mem_rdata[B_VAL];
  wire pte_allows  = (!wr_q || mem_rdata[B_WR]) && (!usr_q || mem_rdata[B_USR]);

  wire [AW-1:0] l1_off = {{(AW-IDX_W-2){1'b0}}, va_q[AW-1:L1_LO], 2'b00};
  wire [AW-1:0] l2_off = {{(AW-IDX_W-2){1'b0}}, va_q[L1_LO-1:OFS_W], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      va_q    <= '0;
      base_q  <= '0;
      tbl_q   <= '0;
      frame_q <= '0;
      stat_q  <= 2'b00;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          base_q <= ptbr;
          wr_q   <= req_write;
          usr_q  <= req_user;
          st     <= FETCH_L1;
        end
        FETCH_L1: st <= WAIT_L1;
        WAIT_L1: if (mem_rvalid) begin
          if (!pte_present) begin
            stat_q <= 2'b01;
            st     <= DONE;
          end else if (!pte_allows) begin
            stat_q <= 2'b11;
            st     <= DONE;
          end else begin
            tbl_q <= {mem_rdata[AW-1:OFS_W], {OFS_W{1'b0}}};
            st    <= FETCH_L2;
          end
        end
        FETCH_L2: st <= WAIT_L2;
        WAIT_L2: if (mem_rvalid) begin
          if (!pte_present)     stat_q <= 2'b10;
          else if (!pte_allows) stat_q <= 2'b11;
          else                  stat_q <= 2'b00;
          frame_q <= mem_rdata[AW-1:OFS_W];
          st      <= DONE;
        end
        DONE:    st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign busy        = (st != IDLE);
  assign resp_valid  = (st == DONE);
  assign resp_status = resp_valid ? stat_q : 2'b00;
  assign resp_paddr  = (resp_valid && stat_q == 2'b00) ? {frame_q, va_q[OFS_W-1:0]} : '0;
  assign mem_req     = (st == FETCH_L1) || (st == FETCH_L2);
  assign mem_addr    = (st == FETCH_L1) ? base_q + l1_off : tbl_q + l2_off;
endmodule

// File: rtl/pt_walker_checks.sv
module pt_walker_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        busy,
  input logic        resp_valid,
  input logic [1:0]  resp_status,
  input logic [31:0] resp_paddr,
  input logic        mem_req,
  input logic        mem_rvalid
);
  logic        pending;
  logic [11:0] ofs_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      ofs_cap <= '0;
    end else begin
      if (mem_req)         pending <= 1'b1;
      else if (mem_rvalid) pending <= 1'b0;
      if (!busy && req_valid) ofs_cap <= req_vaddr[11:0];
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !resp_valid && !mem_req));

  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == 2'b00) |-> resp_paddr[11:0] == ofs_cap);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  p_busy_at_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> busy);

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !busy);

  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status != 2'b00) |-> resp_paddr == 32'h0);

  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_one_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pending);
endmodule

bind pt_walker pt_walker_checks chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .busy(busy), .resp_valid(resp_valid), .resp_status(resp_status),
  .resp_paddr(resp_paddr), .mem_req(mem_req), .mem_rvalid(mem_rvalid)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptbr = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        busy, resp_valid, mem_req;
  logic [1:0]  resp_status;
  logic [31:0] resp_paddr, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .busy(busy), .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_paddr(resp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic [31:0] base;
    logic [31:0] l1;
    logic [31:0] l2;
    logic [2:0]  lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 1'b0, 1'b0, 32'h0010_0000, 32'h0020_0007, 32'hABCD_E007, 3'd1}, // R4 kernel read
    '{32'hFFFF_FFFF, 1'b1, 1'b1, 32'h0077_7000, 32'h0030_0007, 32'h1234_5007, 3'd3}, // R4 user store
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0010_0000, 32'h0040_0006, 32'h0000_0000, 3'd2}, // R5
    '{32'h0040_1000, 1'b0, 1'b1, 32'h0010_0000, 32'h0050_0007, 32'h1234_5006, 3'd4}, // R6
    '{32'h8000_0ABC, 1'b1, 1'b0, 32'h0010_0000, 32'h0060_0005, 32'h0000_0007, 3'd1}, // R7 level 1
    '{32'h0123_4567, 1'b1, 1'b0, 32'h0020_0000, 32'h0070_0007, 32'h0BAD_0005, 3'd2}, // R7 level 2
    '{32'h7FFF_F001, 1'b0, 1'b1, 32'h0010_0000, 32'h0080_0003, 32'h0000_0007, 3'd1}, // R8 level 1
    '{32'h3C00_3FFF, 1'b0, 1'b1, 32'h0010_0000, 32'h0090_0007, 32'h0C0D_E003, 3'd2}, // R8 level 2
    '{32'h5555_5AAA, 1'b0, 1'b0, 32'h0030_0000, 32'h00A0_0001, 32'h0FEE_D001, 3'd3}, // R8 kernel ignores user bit
    '{32'h0000_2000, 1'b1, 1'b1, 32'h0010_0000, 32'h00B0_0000, 32'h0000_0000, 3'd1}  // R7 absent before permission
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input vec_t v, input bit poke);
    logic l1v, l2v, p1, p2;
    logic [1:0]  exp_st;
    logic [31:0] exp_pa, a1, a2;
    int exp_fetch, fetches, cnt;
    bit got;
    l1v = v.l1[0];
    l2v = v.l2[0];
    p1 = (!v.wr || v.l1[1]) && (!v.usr || v.l1[2]);
    p2 = (!v.wr || v.l2[1]) && (!v.usr || v.l2[2]);
    exp_st = !l1v ? 2'b01 : !p1 ? 2'b11 : !l2v ? 2'b10 : !p2 ? 2'b11 : 2'b00;
    exp_pa = (exp_st == 2'b00) ? {v.l2[31:12], v.va[11:0]} : 32'h0;
    exp_fetch = (l1v && p1) ? 2 : 1;
    a1 = v.base + {20'h0, v.va[31:22], 2'b00};
    a2 = {v.l1[31:12], 12'h000} + {20'h0, v.va[21:12], 2'b00};
    fetches = 0;
    cnt = 0;
    got = 1'b0;
    @(negedge clk);
    req_vaddr = v.va; req_write = v.wr; req_user = v.usr; ptbr = v.base; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ptbr = 32'hDEAD_B000;
    chk(busy === 1'b1, "R9 busy after accept", {31'h0, busy}, 32'h1);
    for (int cyc = 0; cyc < 60; cyc++) begin
      if (cyc > 0) @(negedge clk);
      mem_rvalid = 1'b0;
      if (poke) begin
        req_valid = (cyc == 2);
        req_vaddr = 32'hFACE_0000;
      end
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = (fetches == 1) ? v.l1 : v.l2;
        end
      end
      if (mem_req) begin
        fetches++;
        if (fetches == 1) chk(mem_addr === a1, "R2 level-1 entry address", mem_addr, a1);
        else chk(mem_addr === a2, "R3 level-2 entry address", mem_addr, a2);
        cnt = v.lat;
      end
      if (resp_valid) begin
        got = 1'b1;
        chk(resp_status === exp_st, exp_st == 2'b00 ? "R4 status" : exp_st == 2'b01 ? "R5 status" :
            exp_st == 2'b10 ? "R6 status" : "R7/R8 status", {30'h0, resp_status}, {30'h0, exp_st});
        chk(resp_paddr === exp_pa, exp_st == 2'b00 ? "R4 physical address" : "R10 fault address",
            resp_paddr, exp_pa);
        chk(fetches == exp_fetch, "R5 read count", fetches, exp_fetch);
        chk(busy === 1'b1, "R9 busy in response cycle", {31'h0, busy}, 32'h1);
        break;
      end
    end
    mem_rvalid = 1'b0;
    req_valid = 1'b0;
    if (!got) chk(1'b0, "R9 no response", 32'h0, 32'h1);
    @(negedge clk);
    chk(busy === 1'b0 && resp_valid === 1'b0, "R9 R10 idle after response",
        {30'h0, busy, resp_valid}, 32'h0);
  endtask

  initial begin
    @(negedge clk);
    chk(busy === 1'b0 && resp_valid === 1'b0 && mem_req === 1'b0, "R1 reset state",
        {29'h0, busy, resp_valid, mem_req}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) walk(VECS[i], 1'b0);

    walk(VECS[0], 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_req === 1'b0 && busy === 1'b0 && resp_valid === 1'b0,
          "R9 request during walk ignored", {29'h0, mem_req, busy, resp_valid}, 32'h0);
    end

    @(negedge clk);
    req_vaddr = 32'h1234_5678; req_write = 1'b0; req_user = 1'b0; ptbr = 32'h0010_0000;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && resp_valid === 1'b0 && mem_req === 1'b0, "R1 reset mid-walk",
        {29'h0, busy, resp_valid, mem_req}, 32'h0);
    rst_n = 1'b1;
    walk(VECS[1], 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule